// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit DMA channel. It walks a singly linked list of packet descriptors kept in a word-addressed memory. For each descriptor it fetches the four descriptor words and reads the referenced buffer. It sends the packet bytes on a valid/ready byte stream, with a flag on the first byte and a flag on the last byte. When a packet is done, the channel writes the status word back into the descriptor and follows the next pointer.

Software starts the channel by loading a head pointer. The channel clears the per-descriptor owner bit when it has finished a descriptor. When the chain runs out, it sets an end-of-queue bit in the last descriptor and stops. Software can see that bit on a stalled queue and restart the channel by loading the head pointer again. Software acknowledges finished descriptors by writing their address to a completion register. A pending-completion flag stays raised while that register differs from the last descriptor the channel finished. A self-clearing soft reset returns the channel to idle.

The memory port has a fixed read latency of one cycle: read data for a request in one cycle is on `mem_rdata` in the next cycle. On the byte stream, a byte moves on every rising edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the data and both flags hold. Back-pressure may last any number of cycles. The channel never withdraws a byte it has offered, except through soft reset.

Top module: `pdma_tx_chan`

## Requirements
- R1: A descriptor at word address D holds the next pointer at D+0, the buffer word address at D+1, the byte count (low 11 bits) at D+2 and the mode/status word at D+3. Buffer bytes are packed little-endian: byte i of the packet is bits 8*(i mod 4)+7 down to 8*(i mod 4) of the word at buffer address + i/4.
- R2: Each packet appears on the stream as one run of bytes. `tx_first` is high only on byte 0 and `tx_last` only on the final byte. While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_first` and `tx_last` stay unchanged.
- R3: A packet whose byte count is below 60 is sent as exactly 60 bytes, and the bytes after the count are zero. A count of 60 or more is sent unpadded.
- R4: After a packet, the channel writes back the mode word with the owner bit (bit 29) cleared. The end-of-queue bit (bit 28) is set if the next pointer is zero and cleared otherwise. The start (bit 31), end (bit 30) and length bits are kept.
- R5: After finishing a descriptor with a non-zero next pointer, the channel processes the next descriptor. `head_ptr` shows the address of the descriptor in progress and reads zero once the channel is idle.
- R6: A descriptor whose owner bit is clear when fetched sends no bytes. The channel goes idle with `head_ptr` zero and leaves that descriptor unmodified.
- R7: A head-pointer write of a non-zero address while the channel is idle starts it. A write of zero, or any write while the channel is busy, is ignored.
- R8: While `chan_en` is low, no new descriptor fetch begins, and `head_ptr` keeps the pending address. Processing begins once `chan_en` goes high.
- R9: `cmpl_irq` is high exactly when the completion register differs from the address of the last descriptor finished. Writing that address to the register clears the flag.
- R10: A pulse on `srst_wr` holds `srst_busy` high for 4 cycles (the default) and then clears it by itself. The reset leaves the channel idle with `head_ptr` zero, no byte offered and `cmpl_irq` low. The channel accepts a new head pointer afterwards.
- R11: After the channel has stopped with end-of-queue set, a new head-pointer write restarts processing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable level |
| head_wr | input | 1 | Head pointer write strobe |
| head_wdata | input | AW | Head pointer write value |
| head_ptr | output | AW | Current descriptor address, zero when idle |
| cp_wr | input | 1 | Completion register write strobe |
| cp_wdata | input | AW | Completion register write value |
| cmpl_irq | output | 1 | Completion pending flag |
| srst_wr | input | 1 | Soft reset request pulse |
| srst_busy | output | 1 | Soft reset in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after request |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of packet |
| tx_last | output | 1 | Last byte of packet |

## Verification
The bench sends a three-descriptor chain under irregular back-pressure. The chain mixes a long frame, a short frame and one of exactly 64 bytes, so a design that drops a byte while stalled, or mishandles the 60-byte padding, shows up as a data or flag mismatch. It checks the written-back status words; a design that leaves the owner bit set, or marks end-of-queue on a descriptor that has a successor, fails there. It also covers:
- a descriptor already released by software, which must send nothing and leave no trace;
- a disabled channel, which must hold the pending head pointer;
- a head-pointer write during a transfer, which a careless design would take as a second chain;
- restart after end-of-queue;
- a soft reset in the middle of a packet, which must clear the walker and the completion flag together.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;
  localparam int MODE_SOP_BIT = 31;
  localparam int MODE_EOP_BIT = 30;
  localparam int MODE_OWN_BIT = 29;
  localparam int MODE_EOQ_BIT = 28;
  localparam int LEN_BITS     = 11;
  localparam int DESC_WORDS   = 4;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_FETCH = 2'd1,
    W_SEND  = 2'd2,
    W_WB    = 2'd3
  } walk_st_e;
endpackage

// File: rtl/pdma_serializer.sv
`timescale 1ns/1ps
module pdma_serializer #(
  parameter int LW        = 11,
  parameter int MIN_FRAME = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic          word_vld,
  input  logic [31:0]   word_data,
  output logic          word_req,
  output logic [LW-3:0] word_idx,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_first,
  output logic          tx_last,
  output logic          done
);
  localparam logic [LW-1:0] MINF = LW'(MIN_FRAME);

  logic          active, wfull, pend;
  logic [LW-1:0] lenq, total, bidx;
  logic [31:0]   word;
  logic          need_word, pad_word, fire;
  logic [31:0]   shifted;

  assign need_word = active && !wfull && !pend;
  assign pad_word  = (bidx >= lenq);
  assign word_req  = need_word && !pad_word;
  assign word_idx  = bidx[LW-1:2];

  assign shifted   = word >> {bidx[1:0], 3'b000};
  assign tx_valid  = wfull;
  assign tx_data   = (bidx < lenq) ? shifted[7:0] : 8'h00;
  assign tx_first  = (bidx == '0);
  assign tx_last   = (bidx == total - LW'(1));
  assign fire      = wfull && tx_ready;
  assign done      = fire && tx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; wfull <= 1'b0; pend <= 1'b0;
      lenq <= '0; total <= '0; bidx <= '0; word <= '0;
    end else if (clr) begin
      active <= 1'b0; wfull <= 1'b0; pend <= 1'b0;
      bidx <= '0;
    end else if (start) begin
      active <= 1'b1;
      lenq   <= len;
      total  <= (len < MINF) ? MINF : len;
      bidx   <= '0;
      wfull  <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (need_word && pad_word) begin
        word  <= '0;
        wfull <= 1'b1;
      end
      if (word_req) pend <= 1'b1;
      if (word_vld) begin
        word  <= word_data;
        wfull <= 1'b1;
        pend  <= 1'b0;
      end
      if (fire) begin
        bidx <= bidx + LW'(1);
        if (bidx[1:0] == 2'b11 || tx_last) wfull <= 1'b0;
        if (tx_last) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pdma_walker.sv
`timescale 1ns/1ps
module pdma_walker
  import pdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          chan_en,
  input  logic          head_wr,
  input  logic [AW-1:0] head_wdata,
  output logic [AW-1:0] head_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          word_req,
  input  logic [LW-3:0] word_idx,
  output logic          word_vld,
  output logic          ser_start,
  output logic [LW-1:0] ser_len,
  input  logic          ser_done,
  output logic          fin_vld,
  output logic [AW-1:0] fin_addr
);
  walk_st_e      st;
  logic [2:0]    fcnt;
  logic [AW-1:0] cur, nxt_q, buf_q;
  logic [LW-1:0] len_q;
  logic [31:0]   mode_q, wb_word;
  logic          rvld_q, start_q;

  assign head_ptr  = cur;
  assign word_vld  = rvld_q;
  assign ser_start = start_q;
  assign ser_len   = len_q;
  assign fin_vld   = (st == W_WB);
  assign fin_addr  = cur;

  always_comb begin
    wb_word = mode_q;
    wb_word[MODE_OWN_BIT] = 1'b0;
    wb_word[MODE_EOQ_BIT] = (nxt_q == '0);
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    unique case (st)
      W_FETCH: begin
        mem_req  = (fcnt == 3'd0) ? chan_en : (fcnt < 3'd4);
        mem_addr = cur + AW'(fcnt);
      end
      W_SEND: begin
        mem_req  = word_req;
        mem_addr = buf_q + AW'(word_idx);
      end
      W_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur + AW'(DESC_WORDS - 1);
        mem_wdata = wb_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; fcnt <= '0; cur <= '0; nxt_q <= '0; buf_q <= '0;
      len_q <= '0; mode_q <= '0; rvld_q <= 1'b0; start_q <= 1'b0;
    end else if (clr) begin
      st <= W_IDLE; fcnt <= '0; cur <= '0;
      rvld_q <= 1'b0; start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      rvld_q  <= (st == W_SEND) && word_req;
      unique case (st)
        W_IDLE: begin
          if (head_wr && head_wdata != '0) begin
            cur  <= head_wdata;
            fcnt <= '0;
            st   <= W_FETCH;
          end
        end
        W_FETCH: begin
          if (fcnt == 3'd0) begin
            if (chan_en) fcnt <= 3'd1;
          end else begin
            fcnt <= fcnt + 3'd1;
            case (fcnt)
              3'd1: nxt_q <= mem_rdata[AW-1:0];
              3'd2: buf_q <= mem_rdata[AW-1:0];
              3'd3: len_q <= mem_rdata[LW-1:0];
              default: begin
                mode_q <= mem_rdata;
                fcnt   <= '0;
                if (!mem_rdata[MODE_OWN_BIT]) begin
                  cur <= '0;
                  st  <= W_IDLE;
                end else begin
                  start_q <= 1'b1;
                  st      <= W_SEND;
                end
              end
            endcase
          end
        end
        W_SEND: begin
          if (ser_done) st <= W_WB;
        end
        default: begin
          fcnt <= '0;
          if (nxt_q == '0) begin
            cur <= '0;
            st  <= W_IDLE;
          end else begin
            cur <= nxt_q;
            st  <= W_FETCH;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pdma_cmpl.sv
`timescale 1ns/1ps
module pdma_cmpl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cp_wr,
  input  logic [AW-1:0] cp_wdata,
  input  logic          fin_vld,
  input  logic [AW-1:0] fin_addr,
  output logic          irq
);
  logic [AW-1:0] cp_q, done_q;

  assign irq = (cp_q != done_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q <= '0; done_q <= '0;
    end else if (clr) begin
      cp_q <= '0; done_q <= '0;
    end else begin
      if (cp_wr)   cp_q   <= cp_wdata;
      if (fin_vld) done_q <= fin_addr;
    end
  end
endmodule

// File: rtl/pdma_tx_chan.sv
`timescale 1ns/1ps
module pdma_tx_chan
  import pdma_pkg::*;
#(
  parameter int AW          = 16,
  parameter int MIN_FRAME   = 60,
  parameter int SRST_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          head_wr,
  input  logic [AW-1:0] head_wdata,
  output logic [AW-1:0] head_ptr,
  input  logic          cp_wr,
  input  logic [AW-1:0] cp_wdata,
  output logic          cmpl_irq,
  input  logic          srst_wr,
  output logic          srst_busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_first,
  output logic          tx_last
);
  localparam int LW  = LEN_BITS;
  localparam int SCW = $clog2(SRST_CYCLES + 1);

  logic [SCW-1:0] srst_cnt;
  logic           clr;
  logic           word_req, word_vld, ser_start, ser_done, fin_vld;
  logic [LW-3:0]  word_idx;
  logic [LW-1:0]  ser_len;
  logic [AW-1:0]  fin_addr;

  assign srst_busy = (srst_cnt != '0);
  assign clr       = srst_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     srst_cnt <= '0;
    else if (srst_wr && !srst_busy) srst_cnt <= SCW'(SRST_CYCLES);
    else if (srst_busy)             srst_cnt <= srst_cnt - SCW'(1);
  end

  pdma_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk, .rst_n, .clr, .chan_en,
    .head_wr(head_wr && !srst_busy), .head_wdata, .head_ptr,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .word_req, .word_idx, .word_vld,
    .ser_start, .ser_len, .ser_done,
    .fin_vld, .fin_addr
  );

  pdma_serializer #(.LW(LW), .MIN_FRAME(MIN_FRAME)) u_ser (
    .clk, .rst_n, .clr,
    .start(ser_start), .len(ser_len),
    .word_vld, .word_data(mem_rdata), .word_req, .word_idx,
    .tx_ready, .tx_valid, .tx_data, .tx_first, .tx_last,
    .done(ser_done)
  );

  pdma_cmpl #(.AW(AW)) u_cmpl (
    .clk, .rst_n, .clr,
    .cp_wr, .cp_wdata, .fin_vld, .fin_addr,
    .irq(cmpl_irq)
  );
endmodule

// File: rtl/pdma_tx_chan_chk.sv
`timescale 1ns/1ps
module pdma_tx_chan_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst_busy,
  input logic [AW-1:0] head_ptr,
  input logic          cmpl_irq,
  input logic          mem_req,
  input logic          mem_we,
  input logic [31:0]   mem_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_first,
  input logic          tx_last
);
  a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n || srst_busy)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last));

  a_r3_min_frame: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_first |-> !tx_last);

  a_r4_wb_owner_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[29]);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n || srst_busy)
    head_ptr == '0 |-> !tx_valid);

  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy && $past(srst_busy) |-> !tx_valid && head_ptr == '0);

  a_r9_irq_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_busy) |-> !cmpl_irq);
endmodule

bind pdma_tx_chan pdma_tx_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst_busy(srst_busy), .head_ptr(head_ptr),
  .cmpl_irq(cmpl_irq), .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_first(tx_first), .tx_last(tx_last)
);

// File: tb/pdma_tx_chan_test.sv
`timescale 1ns/1ps
module pdma_tx_chan_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chan_en, head_wr, cp_wr, srst_wr;
  logic [AW-1:0] head_wdata, cp_wdata, head_ptr, mem_addr;
  logic          cmpl_irq, srst_busy, mem_req, mem_we;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          tx_valid, tx_ready, tx_first, tx_last;
  logic [7:0]    tx_data;

  always #2.5 clk = ~clk;

  pdma_tx_chan uut (
    .clk, .rst_n, .chan_en, .head_wr, .head_wdata, .head_ptr,
    .cp_wr, .cp_wdata, .cmpl_irq, .srst_wr, .srst_busy,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .tx_valid, .tx_ready, .tx_data, .tx_first, .tx_last
  );

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  typedef struct packed { logic first; logic last; logic [7:0] d; } beat_t;
  beat_t exp_q[$];
  int    n_chk = 0, n_fail = 0;
  bit    sb_ignore = 0;
  int    rdy_mode = 0;
  int    cyc = 0;
  string mon_tag = "R2";
  bit    finished = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: drive ready, then sample the handshake before the next edge
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = (cyc % 3) != 2;
      default: tx_ready = (cyc % 5) < 2;
    endcase
    if (rst_n && tx_valid && tx_ready && !sb_ignore) begin
      if (exp_q.size() == 0) begin
        chk(0, mon_tag, "unexpected stream byte", tx_data, 0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(tx_data == e.d, "R1", "byte value", tx_data, e.d);
        chk(tx_first == e.first && tx_last == e.last, "R2", "first/last flags",
            {tx_first, tx_last}, {e.first, e.last});
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      chk(0, "WDOG", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // R3: expected frame with zero padding up to 60 bytes
  task automatic push_frame(int baddr, int len);
    int total;
    total = (len < 60) ? 60 : len;
    for (int i = 0; i < total; i++) begin
      beat_t b;
      logic [31:0] w;
      w = mem[(baddr + i / 4) & 255];
      b.d = (i < len) ? 8'(w >> (8 * (i % 4))) : 8'h00;
      b.first = (i == 0);
      b.last  = (i == total - 1);
      exp_q.push_back(b);
    end
  endtask

  function automatic logic [31:0] mode_of(int len, bit own);
    return 32'hC000_0000 | (32'(own) << 29) | 32'(len);
  endfunction

  task automatic mkdesc(int d, int nxt, int baddr, int len, bit own);
    mem[d]     = 32'(nxt);
    mem[d + 1] = 32'(baddr);
    mem[d + 2] = 32'(len);
    mem[d + 3] = mode_of(len, own);
  endtask

  task automatic fill(int baddr, int len, int seed);
    for (int i = 0; i < (len + 3) / 4; i++)
      mem[baddr + i] = (32'h9E37_79B9 * 32'(i + 1)) ^ 32'(seed);
  endtask

  task automatic write_head(int a);
    @(negedge clk); head_wr = 1'b1; head_wdata = AW'(a);
    @(negedge clk); head_wr = 1'b0;
  endtask

  task automatic write_cp(int a);
    @(negedge clk); cp_wr = 1'b1; cp_wdata = AW'(a);
    @(negedge clk); cp_wr = 1'b0;
  endtask

  task automatic wait_idle(string tag);
    bit ok;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (head_ptr == '0 && exp_q.size() == 0) begin ok = 1; break; end
    end
    chk(ok, tag, "chain did not drain", exp_q.size(), 0);
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (tx_valid) break;
    end
  endtask

  localparam int D1 = 'h10, D2 = 'h14, D3 = 'h18, D4 = 'h1C, D5 = 'h20;

  initial begin
    int busy_cnt;
    bit saw;
    rst_n = 1'b0; chan_en = 1'b0; head_wr = 1'b0; cp_wr = 1'b0; srst_wr = 1'b0;
    head_wdata = '0; cp_wdata = '0; tx_ready = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(head_ptr == '0, "R5", "reset head_ptr", head_ptr, 0);
    chk(!tx_valid, "R2", "reset tx_valid", tx_valid, 0);
    chk(!cmpl_irq, "R9", "reset irq", cmpl_irq, 0);
    chk(!srst_busy, "R10", "reset srst_busy", srst_busy, 0);

    // chain of three: long, short (padded), exactly 64 (R1 R3 R4 R5)
    rdy_mode = 1; mon_tag = "R5";
    fill('h40, 100, 32'h1111); fill('h60, 20, 32'h2222); fill('h70, 64, 32'h3333);
    mkdesc(D1, D2, 'h40, 100, 1); mkdesc(D2, D3, 'h60, 20, 1); mkdesc(D3, 0, 'h70, 64, 1);
    push_frame('h40, 100); push_frame('h60, 20); push_frame('h70, 64);
    chan_en = 1'b1;
    write_head(D1);
    wait_valid();
    chk(head_ptr == AW'(D1), "R5", "head_ptr during first packet", head_ptr, D1);
    wait_idle("R5");
    chk(mem[D1 + 3] == 32'hC000_0064, "R4", "wb mode mid-chain", mem[D1 + 3], 32'hC000_0064);
    chk(mem[D2 + 3] == 32'hC000_0014, "R4", "wb mode short frame", mem[D2 + 3], 32'hC000_0014);
    chk(mem[D3 + 3] == 32'hD000_0040, "R4", "wb mode end of queue", mem[D3 + 3], 32'hD000_0040);
    chk(cmpl_irq, "R9", "irq pending after chain", cmpl_irq, 1);
    write_cp(D1);
    chk(cmpl_irq, "R9", "irq with stale ack", cmpl_irq, 1);
    write_cp(D3);
    chk(!cmpl_irq, "R9", "irq after full ack", cmpl_irq, 0);

    // restart after end of queue (R11)
    rdy_mode = 0; mon_tag = "R11";
    fill('hC0, 30, 32'h4444);
    mkdesc(D4, 0, 'hC0, 30, 1);
    mem[D3] = 32'(D4);
    chk(mem[D3 + 3][28], "R11", "stalled queue visible", mem[D3 + 3][28], 1);
    push_frame('hC0, 30);
    write_head(D4);
    wait_idle("R11");
    chk(exp_q.size() == 0 && mem[D4 + 3] == 32'hD000_001E, "R11", "restarted frame done",
        mem[D4 + 3], 32'hD000_001E);

    // descriptor already released by software (R6)
    mon_tag = "R6";
    fill('hD0, 61, 32'h5555);
    mkdesc(D5, 0, 'hD0, 61, 0);
    write_head(D5);
    repeat (20) @(negedge clk);
    chk(head_ptr == '0, "R6", "idle after unowned descriptor", head_ptr, 0);
    chk(mem[D5 + 3] == mode_of(61, 0), "R6", "unowned descriptor untouched",
        mem[D5 + 3], mode_of(61, 0));

    // channel disabled holds the pending head (R8)
    rdy_mode = 2; mon_tag = "R8";
    chan_en = 1'b0;
    mkdesc(D5, 0, 'hD0, 61, 1);
    write_head(D5);
    saw = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (tx_valid) saw = 1; end
    chk(!saw, "R8", "no bytes while disabled", saw, 0);
    chk(head_ptr == AW'(D5), "R8", "pending head kept", head_ptr, D5);
    push_frame('hD0, 61);
    chan_en = 1'b1;
    wait_idle("R8");

    // zero write and write while busy ignored (R7)
    rdy_mode = 1; mon_tag = "R7";
    write_head(0);
    chk(head_ptr == '0, "R7", "zero head write ignored", head_ptr, 0);
    mkdesc(D2, 0, 'h60, 20, 1);
    mkdesc(D1, 0, 'h40, 100, 1);
    push_frame('h60, 20);
    write_head(D2);
    wait_valid();
    write_head(D1);
    wait_idle("R7");
    repeat (40) @(negedge clk);
    chk(head_ptr == '0, "R7", "busy head write did not start", head_ptr, 0);
    chk(mem[D1 + 3] == mode_of(100, 1), "R7", "second chain not taken",
        mem[D1 + 3], mode_of(100, 1));

    // soft reset mid-packet (R10); completion reg holds D3, last done D2 -> irq high
    rdy_mode = 0; mon_tag = "R10";
    fill('h80, 200, 32'h6666);
    mkdesc(D3, 0, 'h80, 200, 1);
    push_frame('h80, 200);
    write_head(D3);
    repeat (40) @(negedge clk);
    chk(cmpl_irq, "R9", "irq before soft reset", cmpl_irq, 1);
    sb_ignore = 1;
    @(negedge clk); srst_wr = 1'b1;
    @(negedge clk); srst_wr = 1'b0;
    busy_cnt = 0;
    if (srst_busy) busy_cnt++;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (srst_busy) busy_cnt++; end
    exp_q.delete();
    chk(busy_cnt == 4, "R10", "soft reset busy cycles", busy_cnt, 4);
    chk(!srst_busy, "R10", "soft reset self-clears", srst_busy, 0);
    chk(head_ptr == '0, "R10", "head cleared", head_ptr, 0);
    chk(!tx_valid, "R10", "stream idle", tx_valid, 0);
    chk(!cmpl_irq, "R10", "irq cleared", cmpl_irq, 0);
    sb_ignore = 0;
    repeat (30) @(negedge clk);
    mkdesc(D4, 0, 'hC0, 30, 1);
    push_frame('hC0, 30);
    write_head(D4);
    wait_idle("R10");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule